// File: doc/BRIEF.md
# Audio Clock Regeneration N/CTS Search Engine

This block picks the numerator N and cycle time stamp (CTS) pair that a digital display transmitter sends to a sink so the sink can rebuild the audio sample clock from the link pixel clock. Given a sample rate fs and a pixel clock, both in Hz, it walks every allowed N in ascending order. For each N it forms the fixed-point CTS (16 fractional bits) and an auxiliary count measured against a fixed 24 MHz reference. It then returns the best N, the rounded CTS and the auxiliary count.

A controller sets the two frequencies and pulses `start`. A short setup phase runs seven divisions on one shared sequential divider. These give the N bounds, the ideal N, the two start values and the two per-step increments. After that, each candidate N takes exactly one clock, because the quotients and remainders are carried forward by addition instead of being divided again. `busy` is high while a search runs. `done` rises when the search ends and stays high, with the results held, until the next accepted start.

Top module: `acr_nsearch`

## Requirements
- R1: For a nonzero fs the candidates are every integer N from floor(128·fs/1500) up to floor(128·fs/300), inclusive, visited in ascending order; a returned nonzero solution always lies in that range.
- R2: For each N the fixed-point CTS is floor(pclk·2^16·N/(128·fs)); `best_cts` is that value plus 2^15, shifted right by 16, and the candidate's error is the absolute difference between the fixed-point CTS and the rounded CTS scaled by 2^16.
- R3: The auxiliary count is floor(24000000·2^16·N/(128·fs)); a candidate is eligible only when its low 16 bits are zero, and `best_aux` is that value shifted right by 16.
- R4: An eligible candidate becomes the best when its error is strictly below the best error, or when the errors are equal and |N − floor(128·fs/1000)| is strictly below |best N − floor(128·fs/1000)|.
- R5: Each search starts with best N, CTS and auxiliary count at zero and a best error of 100·2^16, so the first eligible candidate is always taken.
- R6: Accepting a candidate with zero error whose N equals the ideal N ends the sweep at once; each examined candidate costs exactly one clock, so for the same fs the start-to-done latency of a full sweep exceeds that of an early stop by the number of candidates skipped.
- R7: When no candidate is eligible, or fs is zero, the search ends with `no_solution` = 1 and `best_n`, `best_cts` and `best_aux` all zero; fs = 0 completes one clock after the start.
- R8: `start` is taken only while `busy` is low; a start pulse during a search has no effect on that search or its result; `busy` and `done` are never high together; `done` and the results hold until the next accepted start.
- R9: After reset `busy`, `done` and `no_solution` are 0 and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse to begin a search; sampled only when idle |
| fs_hz | input | FS_W (20) | Audio sample rate in Hz |
| pclk_hz | input | PCLK_W (30) | Link pixel clock in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, results valid |
| no_solution | output | 1 | No eligible candidate was found |
| best_n | output | FS_W (20) | Chosen N |
| best_cts | output | PCLK_W (30) | Chosen CTS, rounded to nearest |
| best_aux | output | 25 | Auxiliary 24 MHz count for the chosen N |

## Verification
The 48 kHz rate is paired with a pixel clock that divides exactly, so the search stops early at the ideal N. The same rate is also paired with a clock one hertz higher that forces a full sweep, and the latency gap between the two runs isolates the early exit and the one-clock-per-candidate cost. The 44.1 kHz and 32 kHz rates at common video clocks exercise the error minimisation and the distance tie-break. A prime rate that makes every auxiliary count fractional, and a zero rate, cover the no-solution path. Random rates and clocks from a fixed seed check the incremental quotient arithmetic against direct wide division in the bench, and a start pulse with a zero rate injected mid-search shows that a busy engine ignores new requests.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int FRAC_W   = 16;
    localparam int REF_HZ   = 24000000;
    localparam int REF_W    = 25;
    localparam int ERR_W    = 24;
    localparam int INIT_ERR_INT = 100;

    localparam int DIV_LO   = 1500;   // divisor giving the smallest N
    localparam int DIV_HI   = 300;    // divisor giving the largest N
    localparam int DIV_MID  = 1000;   // divisor giving the ideal N

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_SWEEP = 2'd3
    } acr_state_e;

    typedef enum logic [2:0] {
        OP_NMIN   = 3'd0,
        OP_NMAX   = 3'd1,
        OP_NIDEAL = 3'd2,
        OP_CTS0   = 3'd3,
        OP_AUX0   = 3'd4,
        OP_CTSINC = 3'd5,
        OP_AUXINC = 3'd6
    } acr_op_e;

endpackage

// File: rtl/acr_div.sv
module acr_div #(
    parameter int W = 66
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic [CW-1:0] cnt;
        logic          run;
        logic          done;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        logic [W:0] trial;
        logic       qbit;
        st_d      = st_q;
        st_d.done = 1'b0;
        trial     = '0;
        qbit      = 1'b0;
        if (go && !st_q.run) begin
            st_d.rem = '0;
            st_d.quo = dividend;
            st_d.dvs = divisor;
            st_d.cnt = CW'(W);
            st_d.run = 1'b1;
        end else if (st_q.run) begin
            trial = {st_q.rem, st_q.quo[W-1]};
            if (trial >= {1'b0, st_q.dvs}) begin
                st_d.rem = W'(trial - {1'b0, st_q.dvs});
                qbit     = 1'b1;
            end else begin
                st_d.rem = trial[W-1:0];
            end
            st_d.quo = {st_q.quo[W-2:0], qbit};
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.run;
    assign done = st_q.done;
    assign quo  = st_q.quo;
    assign rem  = st_q.rem;

    // R2
    div_rem_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.dvs != '0) |-> (rem < st_q.dvs));

    // R2
    div_one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/acr_acc.sv
module acr_acc #(
    parameter int QW = 66,
    parameter int RW = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [QW-1:0] q_init,
    input  logic [RW-1:0] r_init,
    input  logic          step,
    input  logic [QW-1:0] q_inc,
    input  logic [RW-1:0] r_inc,
    input  logic [RW-1:0] modulus,
    output logic [QW-1:0] q_val,
    output logic [RW-1:0] r_val
);
    typedef struct packed {
        logic [QW-1:0] q;
        logic [RW-1:0] r;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        logic [RW:0] sum;
        logic        wrap;
        st_d = st_q;
        sum  = {1'b0, st_q.r} + {1'b0, r_inc};
        wrap = (sum >= {1'b0, modulus});
        if (load) begin
            st_d.q = q_init;
            st_d.r = r_init;
        end else if (step) begin
            st_d.r = wrap ? RW'(sum - {1'b0, modulus}) : sum[RW-1:0];
            st_d.q = st_q.q + q_inc + QW'(wrap);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_val = st_q.q;
    assign r_val = st_q.r;

    // R2
    acc_rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && st_q.r < modulus && r_inc < modulus) |=> (st_q.r < modulus));

    // R1
    acc_q_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (st_q.q >= $past(st_q.q)));

endmodule

// File: rtl/acr_eval.sv
module acr_eval
    import acr_pkg::*;
#(
    parameter int DW     = 66,
    parameter int N_W    = 20,
    parameter int CTS_W  = 30
) (
    input  logic [DW-1:0]    cts_fx,
    input  logic [DW-1:0]    aux_fx,
    input  logic [N_W-1:0]   n,
    input  logic [N_W-1:0]   n_ideal,
    input  logic [N_W-1:0]   best_n,
    input  logic [ERR_W-1:0] best_err,
    output logic             accept,
    output logic             perfect,
    output logic [ERR_W-1:0] err,
    output logic [CTS_W-1:0] cts_int,
    output logic [REF_W-1:0] aux_int
);
    localparam int CTS_TOP = FRAC_W + CTS_W;
    localparam int AUX_TOP = FRAC_W + REF_W;

    logic [FRAC_W-1:0] frac;
    logic              round_up;
    logic              cts_fits;
    logic              aux_fits;
    logic              eligible;
    logic [N_W-1:0]    dist_new;
    logic [N_W-1:0]    dist_best;

    always_comb begin
        frac     = cts_fx[FRAC_W-1:0];
        round_up = frac[FRAC_W-1];
        err      = round_up ? ERR_W'((FRAC_W+1)'(1) << FRAC_W) - ERR_W'(frac)
                            : ERR_W'(frac);
        cts_fits = (cts_fx[DW-1:CTS_TOP] == '0);
        aux_fits = (aux_fx[DW-1:AUX_TOP] == '0);
        cts_int  = cts_fx[CTS_TOP-1:FRAC_W] + CTS_W'(round_up);
        aux_int  = aux_fx[AUX_TOP-1:FRAC_W];
        eligible = (aux_fx[FRAC_W-1:0] == '0) && cts_fits && aux_fits;

        dist_new  = (n >= n_ideal) ? (n - n_ideal) : (n_ideal - n);
        dist_best = (best_n >= n_ideal) ? (best_n - n_ideal) : (n_ideal - best_n);

        accept  = eligible &&
                  ((err < best_err) || ((err == best_err) && (dist_new < dist_best)));
        perfect = accept && (err == '0) && (n == n_ideal);
    end

endmodule

// File: rtl/acr_nsearch.sv
module acr_nsearch
    import acr_pkg::*;
#(
    parameter int FS_W   = 20,
    parameter int PCLK_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FS_W-1:0]   fs_hz,
    input  logic [PCLK_W-1:0] pclk_hz,
    output logic              busy,
    output logic              done,
    output logic              no_solution,
    output logic [FS_W-1:0]   best_n,
    output logic [PCLK_W-1:0] best_cts,
    output logic [REF_W-1:0]  best_aux
);
    localparam int N_W   = FS_W;
    localparam int D_W   = FS_W + 7;
    localparam int CTS_W = PCLK_W;
    localparam int DW    = PCLK_W + FRAC_W + N_W;
    localparam logic [DW-1:0]    AUX_NUM  = DW'(REF_HZ) << FRAC_W;
    localparam logic [ERR_W-1:0] ERR_INIT = ERR_W'(INIT_ERR_INT) << FRAC_W;

    typedef struct packed {
        acr_state_e        state;
        acr_op_e           op;
        logic [PCLK_W-1:0] pclk;
        logic [D_W-1:0]    dval;
        logic [N_W-1:0]    nmin;
        logic [N_W-1:0]    nmax;
        logic [N_W-1:0]    nideal;
        logic [N_W-1:0]    n;
        logic [DW-1:0]     cts_qi;
        logic [D_W-1:0]    cts_ri;
        logic [DW-1:0]     aux_qi;
        logic [D_W-1:0]    aux_ri;
        logic [N_W-1:0]    best_n;
        logic [CTS_W-1:0]  best_cts;
        logic [REF_W-1:0]  best_aux;
        logic [ERR_W-1:0]  best_err;
        logic              found;
        logic              done;
        logic              nosol;
    } top_st_t;

    top_st_t st_d, st_q;

    logic           div_go, div_busy, div_done;
    logic [DW-1:0]  div_a, div_b, div_quo, div_rem;
    logic           cts_load, aux_load, acc_step;
    logic [DW-1:0]  cts_fx, aux_fx;
    logic [D_W-1:0] cts_r, aux_r;
    logic           ev_accept, ev_perfect;
    logic [ERR_W-1:0] ev_err;
    logic [CTS_W-1:0] ev_cts;
    logic [REF_W-1:0] ev_aux;
    logic             last_cand;

    acr_div #(.W(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .busy     (div_busy),
        .done     (div_done),
        .quo      (div_quo),
        .rem      (div_rem)
    );

    acr_acc #(.QW(DW), .RW(D_W)) u_acc_cts (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cts_load),
        .q_init  (div_quo),
        .r_init  (div_rem[D_W-1:0]),
        .step    (acc_step),
        .q_inc   (st_q.cts_qi),
        .r_inc   (st_q.cts_ri),
        .modulus (st_q.dval),
        .q_val   (cts_fx),
        .r_val   (cts_r)
    );

    acr_acc #(.QW(DW), .RW(D_W)) u_acc_aux (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (aux_load),
        .q_init  (div_quo),
        .r_init  (div_rem[D_W-1:0]),
        .step    (acc_step),
        .q_inc   (st_q.aux_qi),
        .r_inc   (st_q.aux_ri),
        .modulus (st_q.dval),
        .q_val   (aux_fx),
        .r_val   (aux_r)
    );

    acr_eval #(.DW(DW), .N_W(N_W), .CTS_W(CTS_W)) u_eval (
        .cts_fx   (cts_fx),
        .aux_fx   (aux_fx),
        .n        (st_q.n),
        .n_ideal  (st_q.nideal),
        .best_n   (st_q.best_n),
        .best_err (st_q.best_err),
        .accept   (ev_accept),
        .perfect  (ev_perfect),
        .err      (ev_err),
        .cts_int  (ev_cts),
        .aux_int  (ev_aux)
    );

    // Operand selection for the shared divider.
    always_comb begin
        logic [DW-1:0] pclk_fx;
        pclk_fx = DW'(st_q.pclk) << FRAC_W;
        div_a   = DW'(st_q.dval);
        div_b   = DW'(st_q.dval);
        case (st_q.op)
            OP_NMIN:   div_b = DW'(DIV_LO);
            OP_NMAX:   div_b = DW'(DIV_HI);
            OP_NIDEAL: div_b = DW'(DIV_MID);
            OP_CTS0:   div_a = pclk_fx * DW'(st_q.nmin);
            OP_AUX0:   div_a = AUX_NUM * DW'(st_q.nmin);
            OP_CTSINC: div_a = pclk_fx;
            OP_AUXINC: div_a = AUX_NUM;
            default:   div_a = '0;
        endcase
    end

    assign last_cand = ev_perfect || (st_q.n == st_q.nmax);

    always_comb begin
        st_d     = st_q;
        div_go   = 1'b0;
        cts_load = 1'b0;
        aux_load = 1'b0;
        acc_step = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.best_n   = '0;
                    st_d.best_cts = '0;
                    st_d.best_aux = '0;
                    st_d.best_err = ERR_INIT;
                    st_d.found    = 1'b0;
                    st_d.pclk     = pclk_hz;
                    st_d.dval     = D_W'(fs_hz) << 7;
                    if (fs_hz == '0) begin
                        st_d.done  = 1'b1;
                        st_d.nosol = 1'b1;
                    end else begin
                        st_d.done  = 1'b0;
                        st_d.nosol = 1'b0;
                        st_d.op    = OP_NMIN;
                        st_d.state = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                div_go     = 1'b1;
                st_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (div_done) begin
                    st_d.state = ST_ISSUE;
                    st_d.op    = acr_op_e'(st_q.op + 3'd1);
                    case (st_q.op)
                        OP_NMIN:   st_d.nmin   = div_quo[N_W-1:0];
                        OP_NMAX:   st_d.nmax   = div_quo[N_W-1:0];
                        OP_NIDEAL: st_d.nideal = div_quo[N_W-1:0];
                        OP_CTS0:   cts_load    = 1'b1;
                        OP_AUX0:   aux_load    = 1'b1;
                        OP_CTSINC: begin
                            st_d.cts_qi = div_quo;
                            st_d.cts_ri = div_rem[D_W-1:0];
                        end
                        default: begin
                            st_d.aux_qi = div_quo;
                            st_d.aux_ri = div_rem[D_W-1:0];
                            st_d.n      = st_q.nmin;
                            st_d.state  = ST_SWEEP;
                        end
                    endcase
                end
            end
            default: begin
                if (ev_accept) begin
                    st_d.best_n   = st_q.n;
                    st_d.best_cts = ev_cts;
                    st_d.best_aux = ev_aux;
                    st_d.best_err = ev_err;
                    st_d.found    = 1'b1;
                end
                if (last_cand) begin
                    st_d.state = ST_IDLE;
                    st_d.done  = 1'b1;
                    st_d.nosol = !(st_q.found || ev_accept);
                end else begin
                    st_d.n   = st_q.n + 1'b1;
                    acc_step = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy        = (st_q.state != ST_IDLE);
    assign done        = st_q.done;
    assign no_solution = st_q.nosol;
    assign best_n      = st_q.best_n;
    assign best_cts    = st_q.best_cts;
    assign best_aux    = st_q.best_aux;

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(st_q.state == ST_SWEEP && last_cand)) |=> busy);

    // R7
    nosol_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_solution |-> (best_n == '0 && best_cts == '0 && best_aux == '0));

    // R1
    n_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_solution && st_q.dval != '0) |->
        (best_n >= st_q.nmin && best_n <= st_q.nmax));

    // R4
    best_err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_SWEEP) |=> (st_q.best_err <= $past(st_q.best_err)));

    // R6
    early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_SWEEP && ev_perfect) |=> (done && !busy));

    // R1
    div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> !div_busy);

    // R2
    rem_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> ((div_rem >> D_W) == '0));

    // R3
    acc_rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_SWEEP) |-> (cts_r < st_q.dval && aux_r < st_q.dval));

endmodule

// File: tb/acr_nsearch_tb.sv
module acr_nsearch_tb;

    localparam int  FS_W   = 20;
    localparam int  PCLK_W = 30;
    localparam longint WD_LIMIT = 190000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [FS_W-1:0]   fs_hz = '0;
    logic [PCLK_W-1:0] pclk_hz = '0;
    logic              busy, done, no_solution;
    logic [FS_W-1:0]   best_n;
    logic [PCLK_W-1:0] best_cts;
    logic [24:0]       best_aux;

    int     n_chk  = 0;
    int     n_fail = 0;
    longint cyc    = 0;
    bit     timed_out = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    acr_nsearch #(.FS_W(FS_W), .PCLK_W(PCLK_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .fs_hz       (fs_hz),
        .pclk_hz     (pclk_hz),
        .busy        (busy),
        .done        (done),
        .no_solution (no_solution),
        .best_n      (best_n),
        .best_cts    (best_cts),
        .best_aux    (best_aux)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Direct wide-division model of the search.
    task automatic model(input longint fs, input longint pc,
                         output longint en, output longint ec, output longint ea,
                         output bit nosol, output longint cnt);
        longint lo, hi, id, besterr, cts, aux, err, cf, af, dn, db;
        logic [127:0] d, num;
        bit found;
        en = 0; ec = 0; ea = 0; cnt = 0; found = 0;
        besterr = 100 * 65536;
        if (fs == 0) begin
            nosol = 1;
            return;
        end
        lo = (128 * fs) / 1500;
        hi = (128 * fs) / 300;
        id = (128 * fs) / 1000;
        d  = 128'(128 * fs);
        for (longint n = lo; n <= hi; n++) begin
            cnt++;
            num = (128'(pc) << 16) * 128'(n);
            cf  = longint'(num / d);
            num = (128'(24000000) << 16) * 128'(n);
            af  = longint'(num / d);
            cts = (cf + 32768) >>> 16;
            err = cf - (cts <<< 16);
            if (err < 0) err = -err;
            aux = af >>> 16;
            dn  = (n > id) ? n - id : id - n;
            db  = (en > id) ? en - id : id - en;
            if (((aux <<< 16) == af) && (err < besterr || (err == besterr && dn < db))) begin
                besterr = err; en = n; ec = cts; ea = aux; found = 1;
                if (err == 0 && n == id) break;
            end
        end
        nosol = !found;
    endtask

    task automatic run_case(input longint fs, input longint pc, input bit poke,
                            output longint lat);
        longint en, ec, ea, cnt;
        bit ns;
        lat = 0;
        if (timed_out) return;
        model(fs, pc, en, ec, ea, ns, cnt);
        @(negedge clk);
        fs_hz = FS_W'(fs); pclk_hz = PCLK_W'(pc); start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 1;
        if (poke) begin
            repeat (4) @(negedge clk);
            lat += 4;
            fs_hz = '0; start = 1'b1;
            @(negedge clk);
            start = 1'b0; lat++;
            // R8: start with fs=0 while busy must not finish the search
            chk("R8", "busy after start during search", busy, 1);
            chk("R8", "done after start during search", done, 0);
        end
        while (!done) begin
            if (cyc > WD_LIMIT) begin
                timed_out = 1'b1;
                return;
            end
            @(negedge clk);
            lat++;
        end
        // R1 R4 chosen N, R2 CTS, R3 auxiliary count, R7 flag
        chk("R1/R4", $sformatf("best_n fs=%0d pclk=%0d", fs, pc), best_n, en);
        chk("R2", $sformatf("best_cts fs=%0d pclk=%0d", fs, pc), best_cts, ec);
        chk("R3", $sformatf("best_aux fs=%0d pclk=%0d", fs, pc), best_aux, ea);
        chk("R7", $sformatf("no_solution fs=%0d pclk=%0d", fs, pc), no_solution, ns);
    endtask

    initial begin
        longint lat_a, lat_b, lat_x, en, ec, ea, cnt_full, cnt_early;
        longint held_n;
        bit ns;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "busy in reset", busy, 0);
        chk("R9", "done in reset", done, 0);
        chk("R9", "no_solution in reset", no_solution, 0);
        chk("R9", "best_n in reset", best_n, 0);
        chk("R9", "best_cts+best_aux in reset", best_cts + best_aux, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6: exact match at the ideal N stops early
        run_case(48000, 148500000, 1'b0, lat_a);
        // R6: same fs, inexact clock sweeps the whole range
        run_case(48000, 148500001, 1'b0, lat_b);
        model(48000, 148500000, en, ec, ea, ns, cnt_early);
        model(48000, 148500001, en, ec, ea, ns, cnt_full);
        if (!timed_out)
            chk("R6", "latency gap full vs early stop", lat_b - lat_a, cnt_full - cnt_early);

        // R8: results and done hold after completion
        held_n = best_n;
        repeat (10) @(negedge clk);
        chk("R8", "done held", done, 1);
        chk("R8", "best_n held", best_n, held_n);

        // R4 R5: error minimisation and tie-break at common rates
        run_case(44100, 74250000, 1'b0, lat_x);
        run_case(32000, 27000000, 1'b0, lat_x);

        // R7: prime rate gives no integral auxiliary count
        run_case(30011, 148500000, 1'b0, lat_x);

        // R7: zero rate finishes at once with no solution
        run_case(0, 74250000, 1'b0, lat_x);
        if (!timed_out) chk("R7", "latency for fs=0", lat_x, 1);

        // R8: start during a search is ignored
        run_case(8000, 27000000, 1'b1, lat_x);

        // R2 R3 R4: random rates and clocks
        for (int i = 0; i < 3; i++) begin
            longint rfs, rpc;
            rfs = 1000 + longint'($urandom % 23000);
            rpc = 25000000 + longint'($urandom % 275000000);
            run_case(rfs, rpc, 1'b0, lat_x);
        end

        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule